// File: doc/BRIEF.md
# Interrupt Redirection Unit with Indirect Register Access

This block routes external interrupt pins to interrupt messages. Software reaches all of its state through two bus words: a select word that holds an internal register index, and a data window that reads or writes the internal register the select word points at. Behind the window sit an identification register, a read-only version register and one 64-bit redirection entry per input pin. Each entry is split into a low and a high 32-bit half at two consecutive indices.

Each entry gives its pin a vector, a delivery mode, a destination mode, a destination, a polarity, a trigger mode and a mask. The unit watches the pins. Edge-triggered pins raise one message per active-going transition. Level-triggered pins raise a message while active, then stay quiet until an end-of-interrupt carrying their vector arrives. Pending pins are served lowest number first, one message per valid/ready handshake.

Top module: `irq_steer`

## Requirements
- R1: After reset the select word reads 0, the ID register reads 0, and every entry reads 0x0001_0000 in its low half (only the mask, bit 16, set) and 0 in its high half.
- R2: Bus address 0x00 is the select word, with bits 7:0 writable and bits 31:8 reading 0. Bus address 0x10 is the data window, which accesses the internal index held in the select word. Any other bus address reads 0, and writes to it change nothing.
- R3: Index 0x00 holds a 4-bit ID in bits 27:24 that can be read and written; all its other bits read 0. Index 0x01 is read-only and reads the version parameter (default 0x20) in bits 7:0 and NPINS-1 (23 by default) in bits 23:16, with all other bits 0.
- R4: The entry for pin n sits at index 0x10+2n (low half) and 0x11+2n (high half). The low half has the vector in bits 7:0, the delivery mode in 10:8, the destination mode in 11, the polarity in 13, the remote request in 14 (read-only), the trigger mode in 15 and the mask in 16. The high half has the destination in bits 31:24. All other bits read 0. Any index that does not exist reads 0 and ignores writes.
- R5: An edge-triggered (bit 15 = 0), unmasked pin that goes active raises exactly one message. The message carries the entry's vector, delivery mode, destination mode and destination, and msg_valid is high on the second rising clock edge after the pin changes. Holding the pin active, or releasing it, raises no further message.
- R6: A level-triggered (bit 15 = 1), unmasked pin raises a message while it is active and its remote-request bit is clear; msg_valid is high on the first rising edge after the pin goes active. Loading the message sets the remote-request bit, and no further message comes from that pin while the bit stays set.
- R7: An end-of-interrupt pulse clears the remote-request bit of every level-triggered entry whose vector matches. A pulse with any other vector leaves the bit set. If the pin is still active after the bit clears, a new message is valid on the second rising edge after the pulse.
- R8: Polarity bit 13 = 1 makes a pin active low; a falling input is then the active-going transition.
- R9: A masked pin (bit 16 = 1) raises no message. An edge that occurs while the pin is masked is lost and is not delivered when the mask is later cleared.
- R10: When several pins are pending at once, messages go out in ascending pin order, one per handshake. While msg_valid is high and msg_ready is low, the message fields do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Bus word address (0x00 select, 0x10 window) |
| bus_wr | input | 1 | Bus write strobe |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data, combinational from bus_addr |
| irq_pins | input | NPINS | External interrupt pins |
| eoi_valid | input | 1 | End-of-interrupt pulse |
| eoi_vector | input | 8 | Vector carried by the end-of-interrupt |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Message accepted by the receiver |
| msg_vector | output | 8 | Message vector |
| msg_dmode | output | 3 | Message delivery mode |
| msg_logical | output | 1 | Message destination mode (1 = logical) |
| msg_dest | output | 8 | Message destination |

## Verification
Bus reads are combinational, so the bench samples bus_rdata 1 ns after it sets the address. A register write takes effect at the next rising edge. An edge-mode message is due on the second rising edge after the pin changes, and a level-mode message on the first rising edge. After an end-of-interrupt pulse the message comes one edge later than for a fresh level event, because the remote-request bit clears first. The bench drives every input on the falling edge and checks msg_valid exactly at the due edge, and also one edge before it, so a message that arrives early or late is reported. In the random rounds the bench collects messages with msg_ready held high and compares each one, in order, with a list its own functions build from the entries it programmed.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;

   // One redirection entry, stored without the read-as-zero bits
   typedef struct packed {
      logic [7:0] vec;
      logic [2:0] dmode;
      logic       dlog;
      logic       pol;
      logic       trig;
      logic       mask;
      logic [7:0] dest;
   } rte_t;

   localparam logic [7:0] BUS_SEL_ADDR = 8'h00;
   localparam logic [7:0] BUS_WIN_ADDR = 8'h10;
   localparam logic [7:0] IDX_ID       = 8'h00;
   localparam logic [7:0] IDX_VER      = 8'h01;
   localparam int         IDX_TABLE    = 16;

endpackage

// File: rtl/irq_steer_regs.sv
module irq_steer_regs
   import irq_steer_pkg::*;
#(
   parameter int         NPINS   = 24,
   parameter logic [7:0] VERSION = 8'h20
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [7:0]            bus_addr,
   input  logic                  bus_wr,
   input  logic [31:0]           bus_wdata,
   output logic [31:0]           bus_rdata,
   input  logic [NPINS-1:0]      rirr_set,
   input  logic                  eoi_valid,
   input  logic [7:0]            eoi_vector,
   output rte_t [NPINS-1:0]      ent,
   output logic [NPINS-1:0]      rirr
);

   localparam logic [7:0] MAX_ENTRY = 8'(NPINS - 1);

   logic [7:0]  sel_q;
   logic [3:0]  id_q;
   logic        sel_wr, win_wr;
   logic [31:0] win_data;
   logic [NPINS-1:0] trig_v;

   assign sel_wr = bus_wr && (bus_addr == BUS_SEL_ADDR);
   assign win_wr = bus_wr && (bus_addr == BUS_WIN_ADDR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= '0;
         id_q  <= '0;
      end else begin
         if (sel_wr) sel_q <= bus_wdata[7:0];
         if (win_wr && sel_q == IDX_ID) id_q <= bus_wdata[27:24];
      end
   end

   for (genvar n = 0; n < NPINS; n++) begin : g_ent
      localparam logic [7:0] LO_IDX = 8'(IDX_TABLE + 2*n);
      localparam logic [7:0] HI_IDX = 8'(IDX_TABLE + 2*n + 1);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent[n]      <= '0;
            ent[n].mask <= 1'b1;
         end else if (win_wr && sel_q == LO_IDX) begin
            ent[n].vec   <= bus_wdata[7:0];
            ent[n].dmode <= bus_wdata[10:8];
            ent[n].dlog  <= bus_wdata[11];
            ent[n].pol   <= bus_wdata[13];
            ent[n].trig  <= bus_wdata[15];
            ent[n].mask  <= bus_wdata[16];
         end else if (win_wr && sel_q == HI_IDX) begin
            ent[n].dest  <= bus_wdata[31:24];
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n)
            rirr[n] <= 1'b0;
         else if (rirr_set[n])
            rirr[n] <= 1'b1;
         else if (eoi_valid && ent[n].trig && ent[n].vec == eoi_vector)
            rirr[n] <= 1'b0;
      end

      assign trig_v[n] = ent[n].trig;
   end

   always_comb begin
      win_data = '0;
      if (sel_q == IDX_ID)
         win_data = {4'b0, id_q, 24'b0};
      else if (sel_q == IDX_VER)
         win_data = {8'b0, MAX_ENTRY, 8'b0, VERSION};
      for (int n = 0; n < NPINS; n++) begin
         if (sel_q == 8'(IDX_TABLE + 2*n))
            win_data = {15'b0, ent[n].mask, ent[n].trig, rirr[n], ent[n].pol,
                        1'b0, ent[n].dlog, ent[n].dmode, ent[n].vec};
         else if (sel_q == 8'(IDX_TABLE + 2*n + 1))
            win_data = {ent[n].dest, 24'b0};
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == BUS_SEL_ADDR)      bus_rdata = {24'b0, sel_q};
      else if (bus_addr == BUS_WIN_ADDR) bus_rdata = win_data;
   end

   logic unused_wdata;
   assign unused_wdata = ^{bus_wdata[23:17], bus_wdata[14], bus_wdata[12],
                           bus_wdata[31:28]};

   // R6: a remote-request bit only rises on an entry that was level-triggered
   p_rirr_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((rirr & ~$past(rirr)) & ~$past(trig_v)) == '0);

endmodule

// File: rtl/irq_steer_detect.sv
module irq_steer_detect
   import irq_steer_pkg::*;
#(
   parameter int NPINS = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pins,
   input  rte_t [NPINS-1:0] ent,
   input  logic [NPINS-1:0] rirr,
   input  logic [NPINS-1:0] take,
   output logic [NPINS-1:0] req
);

   for (genvar n = 0; n < NPINS; n++) begin : g_pin
      logic act, act_q, epend;

      assign act = pins[n] ^ ent[n].pol;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            act_q <= 1'b0;
            epend <= 1'b0;
         end else begin
            act_q <= act;
            if (act && !act_q && !ent[n].mask && !ent[n].trig)
               epend <= 1'b1;
            else if (take[n])
               epend <= 1'b0;
         end
      end

      assign req[n] = !ent[n].mask &&
                      (ent[n].trig ? (act && !rirr[n]) : epend);

      // R9: a masked pin never holds a pending edge request into the arbiter
      p_masked_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (ent[n].mask && $past(ent[n].mask)) |-> !req[n]);
   end

endmodule

// File: rtl/irq_steer_arb.sv
module irq_steer_arb #(
   parameter int NPINS = 24,
   parameter int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] req,
   output logic [NPINS-1:0] grant,
   output logic [IDX_W-1:0] idx,
   output logic             any
);

   if (NPINS == 1) begin : g_single
      assign grant = req;
   end else begin : g_chain
      logic [NPINS:0] seen;
      assign seen[0] = 1'b0;
      for (genvar n = 0; n < NPINS; n++) begin : g_bit
         assign grant[n]  = req[n] && !seen[n];
         assign seen[n+1] = seen[n] || req[n];
      end
   end

   always_comb begin
      idx = '0;
      for (int n = NPINS - 1; n >= 0; n--)
         if (req[n]) idx = IDX_W'(n);
   end

   assign any = |req;

   // R10: only requesting pins are granted, and the lowest one wins
   p_grant_in_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~req) == '0);
   p_grant_lowest_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (grant != '0) |-> (((grant - 1'b1) & req) == '0));

endmodule

// File: rtl/irq_steer.sv
module irq_steer
   import irq_steer_pkg::*;
#(
   parameter int         NPINS   = 24,
   parameter logic [7:0] VERSION = 8'h20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [7:0]       bus_addr,
   input  logic             bus_wr,
   input  logic [31:0]      bus_wdata,
   output logic [31:0]      bus_rdata,
   input  logic [NPINS-1:0] irq_pins,
   input  logic             eoi_valid,
   input  logic [7:0]       eoi_vector,
   output logic             msg_valid,
   input  logic             msg_ready,
   output logic [7:0]       msg_vector,
   output logic [2:0]       msg_dmode,
   output logic             msg_logical,
   output logic [7:0]       msg_dest
);

   localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1;

   if (NPINS < 1 || NPINS > 120) begin : g_bad_npins
      $error("irq_steer: NPINS must lie in 1..120 so every entry index fits 8 bits");
   end

   rte_t [NPINS-1:0] ent;
   logic [NPINS-1:0] rirr, req, grant, take, trig_v;
   logic [IDX_W-1:0] idx;
   logic             any, load;

   for (genvar n = 0; n < NPINS; n++) begin : g_trig
      assign trig_v[n] = ent[n].trig;
   end

   assign load = !msg_valid && any;
   assign take = load ? grant : '0;

   irq_steer_regs #(.NPINS(NPINS), .VERSION(VERSION)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_wr     (bus_wr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .rirr_set   (take & trig_v),
      .eoi_valid  (eoi_valid),
      .eoi_vector (eoi_vector),
      .ent        (ent),
      .rirr       (rirr)
   );

   irq_steer_detect #(.NPINS(NPINS)) u_detect (
      .clk   (clk),
      .rst_n (rst_n),
      .pins  (irq_pins),
      .ent   (ent),
      .rirr  (rirr),
      .take  (take),
      .req   (req)
   );

   irq_steer_arb #(.NPINS(NPINS), .IDX_W(IDX_W)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req),
      .grant (grant),
      .idx   (idx),
      .any   (any)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         msg_valid   <= 1'b0;
         msg_vector  <= '0;
         msg_dmode   <= '0;
         msg_logical <= 1'b0;
         msg_dest    <= '0;
      end else if (msg_valid && msg_ready) begin
         msg_valid <= 1'b0;
      end else if (load) begin
         msg_valid   <= 1'b1;
         msg_vector  <= ent[idx].vec;
         msg_dmode   <= ent[idx].dmode;
         msg_logical <= ent[idx].dlog;
         msg_dest    <= ent[idx].dest;
      end
   end

   // R10: a stalled message holds every field
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) &&
         $stable(msg_dest) && $stable(msg_dmode) && $stable(msg_logical)));
   // R5: a message only appears when some pin was requesting
   p_rise_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(msg_valid) |-> $past(any));

endmodule

// File: tb/irq_steer_tb.sv
module irq_steer_tb;

   localparam int NP = 24;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NP-1:0] pins = '0;
   logic        eoi_valid = 1'b0;
   logic [7:0]  eoi_vector = '0;
   logic        msg_valid, msg_ready = 1'b0;
   logic [7:0]  msg_vector, msg_dest;
   logic [2:0]  msg_dmode;
   logic        msg_logical;

   int n_chk = 0, n_bad = 0;

   always #10 clk = ~clk;

   irq_steer #(.NPINS(NP), .VERSION(8'h20)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pins(pins),
      .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .msg_valid(msg_valid),
      .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_dmode(msg_dmode),
      .msg_logical(msg_logical), .msg_dest(msg_dest));

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) begin @(posedge clk); @(negedge clk); end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a; #1; d = bus_rdata;
   endtask

   task automatic wreg(input logic [7:0] i, input logic [31:0] d);
      wr(8'h00, {24'b0, i}); wr(8'h10, d);
   endtask

   task automatic rreg(input logic [7:0] i, output logic [31:0] d);
      wr(8'h00, {24'b0, i}); rd(8'h10, d);
   endtask

   task automatic eoi(input logic [7:0] v);
      eoi_valid = 1'b1; eoi_vector = v; step(1); eoi_valid = 1'b0;
   endtask

   task automatic consume();
      msg_ready = 1'b1; step(1); msg_ready = 1'b0;
   endtask

   function automatic logic [7:0] lo_idx(input int n); return 8'(16 + 2*n); endfunction
   function automatic logic [7:0] hi_idx(input int n); return 8'(17 + 2*n); endfunction
   function automatic logic [31:0] lo_word(input logic [7:0] v, input logic [2:0] dm,
         input logic dl, input logic pol, input logic trig, input logic mask);
      return {15'b0, mask, trig, 1'b0, pol, 1'b0, dl, dm, v};
   endfunction
   function automatic logic [19:0] pack_msg(input logic [7:0] v, input logic [2:0] dm,
         input logic dl, input logic [7:0] d);
      return {v, dm, dl, d};
   endfunction

   logic [19:0] exp_q [NP];
   int          exp_n;

   initial begin : wdog
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      logic [31:0] d;
      void'($urandom(32'h1A2B3C4D));
      step(3);
      rst_n = 1'b1;
      step(1);

      // R1 reset state
      rd(8'h00, d);          chk("R1 select after reset", d, 32'h0);
      rreg(8'h00, d);        chk("R1 id after reset", d, 32'h0);
      rreg(lo_idx(0), d);    chk("R1 entry0 low masked", d, 32'h0001_0000);
      rreg(lo_idx(NP-1), d); chk("R1 entry23 low masked", d, 32'h0001_0000);
      rreg(hi_idx(0), d);    chk("R1 entry0 high zero", d, 32'h0);
      chk("R1 no message after reset", {31'b0, msg_valid}, 32'h0);

      // R3 id and version
      rreg(8'h01, d);        chk("R3 version word", d, {8'h00, 8'd23, 8'h00, 8'h20});
      wreg(8'h00, 32'hFFFF_FFFF); rd(8'h10, d); chk("R3 id writable bits", d, 32'h0F00_0000);
      wreg(8'h01, 32'hFFFF_FFFF); rd(8'h10, d); chk("R3 version read-only", d, {8'h00, 8'd23, 8'h00, 8'h20});

      // R2 bus decode
      wr(8'h00, 32'hFFFF_FF05); rd(8'h00, d); chk("R2 select width", d, 32'h0000_0005);
      rd(8'h04, d);          chk("R2 unused address reads 0", d, 32'h0);
      wr(8'h08, 32'h0000_0001); rd(8'h00, d); chk("R2 unused address write ignored", d, 32'h0000_0005);

      // R4 entry layout and unimplemented indices
      wreg(lo_idx(5), 32'hFFFF_FFFF); rd(8'h10, d); chk("R4 low half fields", d, 32'h0001_AFFF);
      wreg(hi_idx(5), 32'hFFFF_FFFF); rd(8'h10, d); chk("R4 high half dest", d, 32'hFF00_0000);
      wreg(lo_idx(5), 32'h0001_0000);
      wreg(hi_idx(5), 32'h0);
      wreg(8'h40, 32'hFFFF_FFFF); rd(8'h10, d); chk("R4 index past table reads 0", d, 32'h0);
      rreg(8'h02, d);        chk("R4 index 0x02 reads 0", d, 32'h0);
      rreg(8'hFF, d);        chk("R4 index 0xFF reads 0", d, 32'h0);

      // R5 edge mode, pin 3
      wreg(hi_idx(3), 32'h5A00_0000);
      wreg(lo_idx(3), lo_word(8'h41, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0));
      pins[3] = 1'b1;
      step(1); chk("R5 edge not yet valid", {31'b0, msg_valid}, 32'h0);
      step(1); chk("R5 edge valid on 2nd edge", {31'b0, msg_valid}, 32'h1);
      chk("R5 edge message fields", {12'b0, pack_msg(msg_vector, msg_dmode, msg_logical, msg_dest)},
          {12'b0, pack_msg(8'h41, 3'd1, 1'b1, 8'h5A)});
      consume();
      chk("R5 handshake clears valid", {31'b0, msg_valid}, 32'h0);
      step(4); chk("R5 held pin no repeat", {31'b0, msg_valid}, 32'h0);
      pins[3] = 1'b0;
      step(4); chk("R5 release no message", {31'b0, msg_valid}, 32'h0);

      // R8 active-low edge, pin 4
      pins[4] = 1'b1;
      wreg(lo_idx(4), lo_word(8'h42, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0));
      step(3); chk("R8 idle high not active", {31'b0, msg_valid}, 32'h0);
      pins[4] = 1'b0;
      step(2); chk("R8 falling edge fires", {24'b0, msg_valid ? msg_vector : 8'h00}, 32'h42);
      consume();

      // R9 mask
      wreg(lo_idx(6), lo_word(8'h43, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1));
      pins[6] = 1'b1;
      step(5); chk("R9 masked edge silent", {31'b0, msg_valid}, 32'h0);
      wreg(lo_idx(6), lo_word(8'h43, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
      step(5); chk("R9 masked edge lost", {31'b0, msg_valid}, 32'h0);
      pins[6] = 1'b0;
      step(2);

      // R6 level mode, pin 7
      wreg(lo_idx(7), lo_word(8'h55, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0));
      pins[7] = 1'b1;
      step(1); chk("R6 level valid on 1st edge", {24'b0, msg_valid ? msg_vector : 8'h00}, 32'h55);
      consume();
      step(4); chk("R6 remote request blocks repeat", {31'b0, msg_valid}, 32'h0);
      rreg(lo_idx(7), d); chk("R6 remote request bit set", d, 32'h0000_C055);

      // R7 end of interrupt
      eoi(8'h56);
      step(3); chk("R7 wrong vector keeps block", {31'b0, msg_valid}, 32'h0);
      rreg(lo_idx(7), d); chk("R7 wrong vector keeps bit", d, 32'h0000_C055);
      eoi(8'h55);
      chk("R7 not valid one edge after eoi", {31'b0, msg_valid}, 32'h0);
      step(1); chk("R7 resend on 2nd edge", {24'b0, msg_valid ? msg_vector : 8'h00}, 32'h55);
      consume();
      pins[7] = 1'b0;
      eoi(8'h55);
      step(4); chk("R7 inactive pin after eoi silent", {31'b0, msg_valid}, 32'h0);
      rreg(lo_idx(7), d); chk("R7 bit cleared", d, 32'h0000_8055);
      wreg(lo_idx(7), lo_word(8'h55, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1));

      // R10 ordering and stall stability, pins 8 and 9
      wreg(lo_idx(9), lo_word(8'h61, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0));
      wreg(lo_idx(8), lo_word(8'h60, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
      pins[8] = 1'b1; pins[9] = 1'b1;
      step(2); chk("R10 lower pin first", {24'b0, msg_valid ? msg_vector : 8'h00}, 32'h60);
      step(3); chk("R10 stalled message stable", {24'b0, msg_valid ? msg_vector : 8'h00}, 32'h60);
      consume();
      chk("R10 one message per handshake", {31'b0, msg_valid}, 32'h0);
      step(1); chk("R10 next pin follows", {24'b0, msg_valid ? msg_vector : 8'h00}, 32'h61);
      consume();
      pins[8] = 1'b0; pins[9] = 1'b0;
      step(2);

      // R10 / R5 / R9 random rounds on pins 10..23
      for (int it = 0; it < 20; it++) begin
         logic [NP-1:0] fire;
         int got_n;
         fire = '0;
         exp_n = 0;
         for (int p = 10; p < NP; p++) begin
            logic [7:0] v, dst;
            logic [2:0] dm;
            logic dl, m;
            v = 8'($urandom); dst = 8'($urandom); dm = 3'($urandom);
            dl = 1'($urandom); m = (($urandom % 4) == 0);
            fire[p] = 1'($urandom);
            wreg(hi_idx(p), {dst, 24'b0});
            wreg(lo_idx(p), lo_word(v, dm, dl, 1'b0, 1'b0, m));
            if (fire[p] && !m) begin
               exp_q[exp_n] = pack_msg(v, dm, dl, dst);
               exp_n++;
            end
         end
         pins = pins | fire;
         msg_ready = 1'b1;
         got_n = 0;
         for (int c = 0; c < 40; c++) begin
            step(1);
            if (msg_valid) begin
               if (got_n < exp_n)
                  chk("R10 random order message",
                      {12'b0, pack_msg(msg_vector, msg_dmode, msg_logical, msg_dest)},
                      {12'b0, exp_q[got_n]});
               got_n++;
            end
         end
         msg_ready = 1'b0;
         chk("R9 random message count", 32'(got_n), 32'(exp_n));
         pins = pins & ~fire;
         step(3);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule